// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block sits on a two-wire serial bus as a slave and gives an external master byte-wide read and write access to a 128-entry register file. It samples the clock and data lines with the system clock through two-stage synchronisers. From the sampled lines it recognises start, repeated start and stop conditions, as well as rising and falling clock edges. The register file lives outside the block and is reached through a synchronous port. A write strobe stores one byte. A read strobe returns data on the following cycle.

A transaction opens with a device-address byte. When the address matches, the master sends a sub-address byte. Its low seven bits load a register pointer, and its top bit chooses whether that pointer advances after each data byte. Data bytes that follow in the same write phase go to the pointed register. To read, the master sets the pointer in a write phase, issues a repeated start, then addresses the device with the read bit set. The block then returns bytes for as long as the master acknowledges them.

Top module: `twi_reg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 0x1D is acknowledged by pulling SDA low during the ninth clock; bit 0 of that byte selects read (1) or write (0).
- R2: An address byte with any other seven-bit value gets no acknowledge. SDA stays released and no register is written until the next start condition.
- R3: SDA falling while SCL is high is a start condition and SDA rising while SCL is high is a stop condition; after a stop the block ignores the bus until the next start.
- R4: In a write phase, the first byte after the address is the sub-address. Its bits 6:0 load the register pointer, and it is acknowledged.
- R5: Each further byte of a write phase is acknowledged and written MSB-first-assembled into the pointed register.
- R6: When bit 7 of the sub-address is 1, the pointer advances by one after every data byte in either direction and wraps from 127 to 0.
- R7: When bit 7 of the sub-address is 0, all data bytes of the transaction, written or read, use the same register.
- R8: After a repeated start with the read bit, the block sends the pointed register MSB first, changing SDA only while SCL is low.
- R9: During a read, the block sends another byte after a master acknowledge. After a not-acknowledge it releases SDA and waits for the next start.
- R10: The SDA drive never changes while SCL stays high.
- R11: A start or stop that arrives partway through a byte discards that byte without a register write; a start restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | 7 | Register file address (the pointer) |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_re |

## Verification
The address path is tried with all 128 seven-bit values, and both direction bits are spread across them. This separates the single matching address from every near miss. One auto-incrementing burst writes all 128 registers with arithmetically distinct values. A second burst reads 130 bytes starting at 126. A wrong pointer step, a missed wrap or a bit-order error therefore shows up as a value mismatch. A non-incrementing write of three bytes, followed by a non-incrementing read, tells the fixed-pointer mode apart from the advancing one. Transfers cut short by a start or a stop mid-byte must leave the target register at its earlier value.

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h1D,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_drive_low,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WR, S_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] shreg, txbuf, wdata;
  logic [PTR_W-1:0] ptr;
  logic       autoinc, rnw, nack, sda_low, we_q, rd_req, rd_pend;

  wire scl_s  = scl_sy[1];
  wire sda_s  = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;

  assign sda_drive_low = sda_low;
  assign reg_addr      = ptr;
  assign reg_wdata     = wdata;
  assign reg_we        = we_q;
  assign reg_re        = rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      txbuf   <= '0;
      wdata   <= '0;
      ptr     <= '0;
      autoinc <= 1'b0;
      rnw     <= 1'b0;
      nack    <= 1'b0;
      sda_low <= 1'b0;
      we_q    <= 1'b0;
      rd_req  <= 1'b0;
      rd_pend <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      rd_req  <= 1'b0;
      rd_pend <= rd_req;
      if (rd_pend) txbuf <= reg_rdata;
      if (we_q) ptr <= ptr + PTR_W'(autoinc);
      if (start_c) begin
        state   <= S_ADDR;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else if (stop_c) begin
        state   <= S_IDLE;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else if (state != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
            if (state != S_RD) shreg <= {shreg[6:0], sda_s};
          end else if (cnt == 4'd8) begin
            cnt  <= 4'd9;
            nack <= sda_s;
          end
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (state)
              S_ADDR:
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_low <= 1'b1;
                  rnw     <= shreg[0];
                  rd_req  <= shreg[0];
                end else begin
                  state <= S_IDLE;
                end
              S_SUB: begin
                sda_low <= 1'b1;
                ptr     <= shreg[PTR_W-1:0];
                autoinc <= shreg[7];
              end
              S_WR: begin
                sda_low <= 1'b1;
                we_q    <= 1'b1;
                wdata   <= shreg;
              end
              S_RD: begin
                sda_low <= 1'b0;
                ptr     <= ptr + PTR_W'(autoinc);
                rd_req  <= 1'b1;
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            cnt     <= '0;
            sda_low <= 1'b0;
            case (state)
              S_ADDR:
                if (rnw) begin
                  state   <= S_RD;
                  shreg   <= txbuf;
                  sda_low <= ~txbuf[7];
                end else begin
                  state <= S_SUB;
                end
              S_SUB: state <= S_WR;
              S_RD:
                if (nack) begin
                  state <= S_IDLE;
                end else begin
                  shreg   <= txbuf;
                  sda_low <= ~txbuf[7];
                end
              default: ;
            endcase
          end else if (state == S_RD && cnt != 4'd0) begin
            shreg   <= {shreg[6:0], 1'b0};
            sda_low <= ~shreg[6];
          end
        end
      end
    end
  end

  assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |-> $stable(sda_low));

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_low);

  assert_write_only_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (state == S_WR));

  assert_read_only_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> (state == S_RD || state == S_ADDR));

  assert_single_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  assert_stop_goes_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE));

  assert_start_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == S_ADDR && cnt == 4'd0));

endmodule

// File: tb/twi_reg_slave_test.sv
module twi_reg_slave_test;
  localparam int Q = 4;
  localparam int H = 8;
  localparam logic [6:0] DEV = 7'h1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_drive_low, reg_we, reg_re;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  int n_chk = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int drv_cnt = 0;
  int steady_viol = 0;
  logic prev_scl = 1'b1;
  logic prev_drv = 1'b0;
  wire sda_bus = m_sda & ~sda_drive_low;

  always #4 clk = ~clk;

  twi_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_drive_low(sda_drive_low), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_we) mem[reg_addr] <= reg_wdata;
      if (reg_re) reg_rdata <= mem[reg_addr];
    end
  end

  always @(posedge clk) begin
    if (reg_we) we_cnt++;
    if (sda_drive_low) drv_cnt++;
    if (rst_n && prev_scl && m_scl && (prev_drv != sda_drive_low)) steady_viol++;
    prev_scl <= m_scl;
    prev_drv <= sda_drive_low;
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; w(H);
    m_sda = 1'b0; w(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_rstart();
    w(Q); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(H);
    m_sda = 1'b0; w(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b1; w(H);
    m_sda = 1'b1; w(H);
  endtask

  task automatic send_bit(input logic b);
    w(Q); m_sda = b; w(Q); m_scl = 1'b1; w(H); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(Q); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(H/2);
    ack = ~sda_bus;
    w(H/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(H/2);
      d[i] = sda_bus;
      w(H/2); m_scl = 1'b0;
    end
    w(Q); m_sda = ~ack; w(Q); m_scl = 1'b1; w(H); m_scl = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int we0, drv0;
    w(5);
    chk(sda_drive_low == 1'b0, "R3 reset sda", sda_drive_low, 0);
    chk(reg_we == 1'b0 && reg_re == 1'b0, "R3 reset strobes", {reg_we, reg_re}, 0);
    rst_n = 1'b1;
    w(5);

    // R1 R4 R5 R6: burst write all registers from pointer 0 with auto-increment
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 address ack", a, 1);
    send_byte(8'h80, a);       chk(a, "R4 sub ack", a, 1);
    for (int i = 0; i < 128; i++) begin
      send_byte(pat(i), a);
      chk(a, "R5 data ack", a, 1);
    end
    bus_stop();
    w(4);
    for (int i = 0; i < 128; i++) chk(mem[i] == pat(i), "R5 R6 written", mem[i], pat(i));

    // R8 R9 R6: burst read from 126 across the wrap
    bus_start();
    send_byte({DEV, 1'b0}, a); chk(a, "R1 write ack", a, 1);
    send_byte(8'hFE, a);       chk(a, "R4 sub ack", a, 1);
    bus_rstart();
    send_byte({DEV, 1'b1}, a); chk(a, "R1 read ack", a, 1);
    for (int k = 0; k < 130; k++) begin
      recv_byte(d, k != 129);
      chk(d == pat((126 + k) % 128), "R8 R6 read data", d, pat((126 + k) % 128));
    end
    w(Q);
    chk(sda_drive_low == 1'b0, "R9 released after nack", sda_drive_low, 0);
    bus_stop();
    w(4);
    chk(sda_drive_low == 1'b0, "R3 released after stop", sda_drive_low, 0);

    // R7: fixed pointer write then read
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a); chk(a, "R4 sub ack", a, 1);
    send_byte(8'hA1, a);
    send_byte(8'hB2, a);
    send_byte(8'hC3, a); chk(a, "R5 ack", a, 1);
    bus_stop();
    w(4);
    chk(mem[16] == 8'hC3, "R7 same register", mem[16], 8'hC3);
    chk(mem[17] == pat(17), "R7 neighbour untouched", mem[17], pat(17));
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a);
    bus_rstart();
    send_byte({DEV, 1'b1}, a);
    for (int k = 0; k < 3; k++) begin
      recv_byte(d, k != 2);
      chk(d == 8'hC3, "R7 fixed read", d, 8'hC3);
    end
    bus_stop();

    // R2: every other address is ignored
    we0 = we_cnt; drv0 = drv_cnt;
    for (int ad = 0; ad < 128; ad++) begin
      if (ad != int'(DEV)) begin
        logic a1, a2, a3;
        bus_start();
        send_byte({7'(ad), 1'(ad % 2)}, a1);
        send_byte(8'h05, a2);
        send_byte(8'hEE, a3);
        bus_stop();
        chk(!a1 && !a2 && !a3, "R2 no ack on mismatch", {a1, a2, a3}, 0);
      end
    end
    chk(we_cnt == we0, "R2 no write on mismatch", we_cnt - we0, 0);
    chk(drv_cnt == drv0, "R2 sda never driven", drv_cnt - drv0, 0);
    chk(mem[5] == pat(5), "R2 register intact", mem[5], pat(5));

    // R11: start in the middle of a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h85, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_rstart();
    send_byte({DEV, 1'b0}, a); chk(a, "R11 address after abort", a, 1);
    send_byte(8'h06, a);
    send_byte(8'h5A, a);
    bus_stop();
    w(4);
    chk(mem[5] == pat(5), "R11 aborted byte not written", mem[5], pat(5));
    chk(mem[6] == 8'h5A, "R11 new transfer written", mem[6], 8'h5A);

    // R11 R3: stop in the middle of a data byte
    we0 = we_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h07, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_stop();
    w(4);
    chk(we_cnt == we0, "R11 stop mid-byte no write", we_cnt - we0, 0);
    chk(mem[7] == pat(7), "R11 register intact", mem[7], pat(7));
    chk(sda_drive_low == 1'b0, "R3 idle after stop", sda_drive_low, 0);

    chk(steady_viol == 0, "R10 sda steady while scl high", steady_viol, 0);
    summary();
    $finish;
  end
endmodule